// File: doc/BRIEF.md
# Chainable SPI Slave Port

This block is an SPI slave that runs entirely in a faster system clock domain. The serial clock, the data input and the active-low select are brought in through synchronisers. Edges of the serial clock are then found by comparing the synchronised level with its previous value. Clock polarity and phase are static mode inputs. The word length can be 8, 12 or 16 bits. Each clock cycle moves one bit in and one bit out, most significant bit first.

At the start of every selection the slave loads its shift register from a parallel transmit word. When a whole word has been sampled, the received word appears on a parallel output together with a one-cycle valid pulse. A chain-mode input decides what happens to clocks beyond one word:

- **Mode 0:** extra clocks are ignored until the next selection.
- **Mode 1:** shifting continues, so each received word is sent out on MISO during the next group of clocks. This lets several slaves share one select line in a daisy chain.

MISO is driven only while the slave is selected. The output-enable pin is meant to control an external three-state buffer.

Top module: `spi_slv_chain`

## Requirements
- R1: After reset, miso_oe_o is 0, rx_valid_o is 0 and rx_word_o is 0.
- R2: The idle level of SCLK equals cpol_i. The leading edge leaves that level and the trailing edge returns to it. With cpha_i=0 MOSI is sampled on the leading edge and MISO changes on the trailing edge. With cpha_i=1 MISO changes on the leading edge and MOSI is sampled on the trailing edge.
- R3: The first MOSI bit of a word becomes the MSB of rx_word_o. MISO sends bits w-1 down to 0 of the transmit word, one per clock, at the same time as reception.
- R4: While ss_ni is high, miso_oe_o is 0 and SCLK and MOSI activity changes neither the outputs nor the word that the next selection sends.
- R5: When the w-th bit of a word is sampled, rx_word_o takes the received word and rx_valid_o is high for exactly one system clock.
- R6: wsize_i selects w as follows: 0 gives 8, 1 gives 12, 2 and 3 give 16. Only tx_word_i[w-1:0] is sent. The received word sits in rx_word_o[w-1:0], and the upper bits are zero.
- R7: With chain_i=0, clocks after the w-th sample produce no further valid pulse, and MISO holds bit 0 of the transmit word until deselection.
- R8: With chain_i=1, shifting continues while selected. Every w samples produce one valid pulse, and the word received in one group leaves MISO, MSB first, during the next group.
- R9: If ss_ni rises before w bits are sampled, the partial word is dropped without a valid pulse. The next selection starts again from bit 0.
- R10: With cpha_i=0, MISO carries bit w-1 of the transmit word as soon as the select is recognised, before any SCLK edge.
- R11: tx_word_i is captured at the start of each selection, so successive selections send fresh words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpol_i | input | 1 | SCLK idle level |
| cpha_i | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| wsize_i | input | 2 | Word length select (0: 8, 1: 12, 2/3: 16) |
| chain_i | input | 1 | 0: ignore extra clocks; 1: keep shifting |
| tx_word_i | input | 16 | Word to send, loaded at selection start |
| sclk_i | input | 1 | Serial clock from the master (asynchronous) |
| mosi_i | input | 1 | Serial data from the master (asynchronous) |
| ss_ni | input | 1 | Slave select, active low (asynchronous) |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | MISO drive enable, high only while selected |
| rx_word_o | output | 16 | Last complete received word, right aligned |
| rx_valid_o | output | 1 | One-cycle pulse when rx_word_o updates |

## Verification
The bench runs full single-word transfers under all four polarity and phase combinations. A swapped edge or a reversed bit order shows up as a shifted or mirrored word on either pin.

Words of 12 and 16 bits, including wsize code 3, show whether the bit counter and the MISO tap follow the selected length. Transfers with extra clocks separate the two chain modes: mode 0 must hold bit 0 and post one word, while mode 1 must return the first received word and post two. Aborted selections and clock activity while deselected show that partial words are dropped and nothing leaks across selections. These directed cases are mixed with seeded random transfers of random mode, length and data.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
  localparam int unsigned MAX_W = 16;
  localparam int unsigned CNT_W = $clog2(MAX_W + 1);

  typedef enum logic [1:0] {
    WS_8   = 2'd0,
    WS_12  = 2'd1,
    WS_16  = 2'd2,
    WS_16B = 2'd3
  } wsel_e;

  function automatic logic [CNT_W-1:0] word_len(input logic [1:0] sel);
    case (wsel_e'(sel))
      WS_8:    word_len = CNT_W'(8);
      WS_12:   word_len = CNT_W'(12);
      default: word_len = CNT_W'(16);
    endcase
  endfunction

  function automatic logic [MAX_W-1:0] word_mask(input logic [CNT_W-1:0] len);
    word_mask = '0;
    for (int k = 0; k < MAX_W; k++)
      if (CNT_W'(k) < len) word_mask[k] = 1'b1;
  endfunction
endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) stg_q[k] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_slv_edge.sv
module spi_slv_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_s_i,
  input  logic ss_ns_i,
  input  logic cpol_i,
  input  logic cpha_i,
  output logic sel_o,
  output logic start_o,
  output logic sample_o,
  output logic shift_o
);
  logic sclk_q, ss_q, lead, trail;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      ss_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_s_i;
      ss_q   <= ss_ns_i;
    end
  end

  assign sel_o   = !ss_ns_i;
  assign start_o = ss_q && !ss_ns_i;
  // edges count only while selected
  assign lead  = sel_o && (sclk_q == cpol_i) && (sclk_s_i != cpol_i);
  assign trail = sel_o && (sclk_q != cpol_i) && (sclk_s_i == cpol_i);
  assign sample_o = cpha_i ? trail : lead;
  assign shift_o  = cpha_i ? lead  : trail;

  assert_sample_on_change_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> (sclk_s_i != $past(sclk_s_i)));
  assert_sample_level_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> (sclk_s_i == (cpol_i ^ !cpha_i)));
endmodule

// File: rtl/spi_slv_shift.sv
module spi_slv_shift
  import spi_slv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             start_i,
  input  logic             sample_i,
  input  logic             shift_i,
  input  logic             mosi_i,
  input  logic             chain_i,
  input  logic [CNT_W-1:0] wlen_i,
  input  logic [MAX_W-1:0] tx_word_i,
  output logic [MAX_W-1:0] rx_word_o,
  output logic             rx_valid_o,
  output logic             miso_o
);
  localparam int unsigned IDX_W = $clog2(MAX_W);

  logic [MAX_W-1:0] sr_q, sr_nxt, mask;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] msb_idx;
  logic             done_q, miso_q, last_bit;

  assign sr_nxt   = {sr_q[MAX_W-2:0], mosi_i};
  assign mask     = word_mask(wlen_i);
  assign msb_idx  = IDX_W'(wlen_i - CNT_W'(1));
  assign last_bit = (cnt_q == wlen_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q       <= '0;
      cnt_q      <= '0;
      done_q     <= 1'b0;
      miso_q     <= 1'b0;
      rx_word_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      if (!sel_i) begin
        cnt_q  <= '0;
        done_q <= 1'b0;
      end else if (start_i) begin
        sr_q   <= tx_word_i;
        miso_q <= tx_word_i[msb_idx];
        cnt_q  <= '0;
        done_q <= 1'b0;
      end else if (!done_q) begin
        if (sample_i) begin
          sr_q <= sr_nxt;
          if (last_bit) begin
            cnt_q      <= '0;
            rx_word_o  <= sr_nxt & mask;
            rx_valid_o <= 1'b1;
            done_q     <= !chain_i;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end else if (shift_i) begin
          miso_q <= sr_q[msb_idx];
        end
      end
    end
  end

  assign miso_o = miso_q;

  assert_valid_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
  assert_abort_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> (cnt_q == '0 && !rx_valid_o));
  assert_idle_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> $stable(sr_q));
  assert_stop_after_word_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && sel_i && !start_i) |=> (!rx_valid_o && $stable(miso_q)));
endmodule

// File: rtl/spi_slv_chain.sv
module spi_slv_chain
  import spi_slv_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic [1:0]       wsize_i,
  input  logic             chain_i,
  input  logic [MAX_W-1:0] tx_word_i,
  input  logic             sclk_i,
  input  logic             mosi_i,
  input  logic             ss_ni,
  output logic             miso_o,
  output logic             miso_oe_o,
  output logic [MAX_W-1:0] rx_word_o,
  output logic             rx_valid_o
);
  logic [2:0] raw, synced;
  logic       sel, start, sample, shift, miso_int;

  assign raw = {ss_ni, sclk_i, mosi_i};

  spi_slv_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i, .rst_ni, .d_i(raw), .q_o(synced)
  );

  spi_slv_edge u_edge (
    .clk_i, .rst_ni,
    .sclk_s_i(synced[1]), .ss_ns_i(synced[2]),
    .cpol_i, .cpha_i,
    .sel_o(sel), .start_o(start), .sample_o(sample), .shift_o(shift)
  );

  spi_slv_shift u_shift (
    .clk_i, .rst_ni,
    .sel_i(sel), .start_i(start), .sample_i(sample), .shift_i(shift),
    .mosi_i(synced[0]), .chain_i,
    .wlen_i(word_len(wsize_i)), .tx_word_i,
    .rx_word_o, .rx_valid_o, .miso_o(miso_int)
  );

  assign miso_oe_o = sel;
  assign miso_o    = sel ? miso_int : 1'b0;
endmodule

// File: tb/spi_slv_chain_tb.sv
module spi_slv_chain_tb;
  localparam int CLK_P = 10;
  localparam int H     = 6;

  logic        clk = 0, rst_n = 0;
  logic        cpol = 0, cpha = 0, chain = 0;
  logic [1:0]  wsize = 0;
  logic [15:0] tx = 0;
  logic        sclk = 0, mosi = 0, ss_n = 1;
  logic        miso, miso_oe, rx_valid;
  logic [15:0] rx_word;

  int n_chk = 0, n_bad = 0, vcount = 0;
  logic [15:0] vwords [8];

  always #(CLK_P/2) clk = ~clk;

  spi_slv_chain u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cpol_i(cpol), .cpha_i(cpha), .wsize_i(wsize),
    .chain_i(chain), .tx_word_i(tx), .sclk_i(sclk), .mosi_i(mosi), .ss_ni(ss_n),
    .miso_o(miso), .miso_oe_o(miso_oe), .rx_word_o(rx_word), .rx_valid_o(rx_valid)
  );

  always @(negedge clk)
    if (rst_n && rx_valid) begin
      if (vcount < 8) vwords[vcount] = rx_word;
      vcount = vcount + 1;
    end

  function automatic int wl(input logic [1:0] s);
    return (s == 2'd0) ? 8 : (s == 2'd1) ? 12 : 16;
  endfunction

  function automatic logic [47:0] msk(input int w);
    return (48'd1 << w) - 48'd1;
  endfunction

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic select_only(input bit pause_after);
    @(negedge clk); ss_n = 0;
    repeat (8) @(negedge clk);
    if (pause_after) begin ss_n = 1; repeat (10) @(negedge clk); end
  endtask

  task automatic xfer(input int n, input logic [47:0] mo, output logic [47:0] mi);
    mi = '0; vcount = 0;
    @(negedge clk); sclk = cpol; ss_n = 0;
    repeat (8) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      if (!cpha) begin
        mosi = mo[i]; repeat (H) @(negedge clk);
        mi[i] = miso; sclk = ~cpol; repeat (H) @(negedge clk);
        sclk = cpol;
      end else begin
        sclk = ~cpol; mosi = mo[i]; repeat (H) @(negedge clk);
        mi[i] = miso; sclk = cpol; repeat (H) @(negedge clk);
      end
    end
    repeat (H) @(negedge clk); ss_n = 1;
    repeat (10) @(negedge clk);
  endtask

  task automatic one_word(input string req, input logic [47:0] mo);
    logic [47:0] mi;
    int w;
    w = wl(wsize);
    xfer(w, mo, mi);
    check({req, " rx count"}, 48'(vcount), 48'd1);
    check({req, " rx word"}, 48'(vwords[0]), mo & msk(w));
    check({req, " miso bits"}, mi, 48'(tx) & msk(w));
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [47:0] mi, mo, exp;
    int w;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 oe", 48'(miso_oe), 48'd0);
    check("R1 valid", 48'(rx_valid), 48'd0);
    check("R1 word", 48'(rx_word), 48'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R2 R3: all four polarity/phase combinations, 8-bit
    for (int m = 0; m < 4; m++) begin
      cpol = m[1]; cpha = m[0]; wsize = 0; chain = 0;
      sclk = cpol; tx = 16'h00A5 ^ 16'(m);
      repeat (4) @(negedge clk);
      one_word("R2 R3 R5", 48'h3C ^ 48'(m * 17));
    end

    // R10: first bit present before any clock, R4 oe follows select
    cpol = 0; cpha = 0; wsize = 1; tx = 16'h0800; sclk = 0;
    repeat (4) @(negedge clk);
    check("R4 oe idle", 48'(miso_oe), 48'd0);
    @(negedge clk); ss_n = 0;
    repeat (8) @(negedge clk);
    check("R10 first bit", 48'(miso), 48'd1);
    check("R4 oe selected", 48'(miso_oe), 48'd1);
    ss_n = 1; repeat (10) @(negedge clk);
    check("R4 oe released", 48'(miso_oe), 48'd0);

    // R4: activity while deselected is ignored
    vcount = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); sclk = ~sclk; mosi = i[1];
    end
    sclk = cpol; repeat (6) @(negedge clk);
    check("R4 no valid while idle", 48'(vcount), 48'd0);
    check("R4 oe during idle clocks", 48'(miso_oe), 48'd0);
    tx = 16'h0ABC;
    one_word("R4 R11 after idle", 48'h5A3);

    // R6: 16-bit and code 3
    cpol = 1; cpha = 1; wsize = 2; tx = 16'hBEEF; sclk = 1;
    repeat (4) @(negedge clk);
    one_word("R6 16b", 48'hC0DE);
    wsize = 3; tx = 16'h1357;
    one_word("R6 code3", 48'h8001);

    // R7: extra clocks ignored in mode 0
    for (int p = 0; p < 2; p++) begin
      cpol = 0; cpha = p[0]; wsize = 0; chain = 0; tx = 16'hFF96; sclk = 0;
      repeat (4) @(negedge clk);
      xfer(12, 48'hA5F, mi);
      check("R7 one valid", 48'(vcount), 48'd1);
      check("R7 word", 48'(vwords[0]), 48'hA5);
      check("R7 miso hold", mi, {40'd0, 8'h96, 4'h0});
    end

    // R8: chain mode, two words back to back
    for (int p = 0; p < 2; p++) begin
      cpol = p[0]; cpha = !p[0]; wsize = 1; chain = 1; tx = 16'hF123; sclk = cpol;
      repeat (4) @(negedge clk);
      mo = 48'h9A4_6C1;
      xfer(24, mo, mi);
      exp = {24'd0, 12'h123, 12'h9A4};
      check("R8 two valids", 48'(vcount), 48'd2);
      check("R8 word0", 48'(vwords[0]), 48'h9A4);
      check("R8 word1", 48'(vwords[1]), 48'h6C1);
      check("R8 pass-through", mi, exp);
    end
    chain = 0;

    // R9: abort mid-word, then a clean word
    cpol = 0; cpha = 1; wsize = 0; tx = 16'h0033; sclk = 0;
    repeat (4) @(negedge clk);
    xfer(5, 48'h1F, mi);
    check("R9 no valid on abort", 48'(vcount), 48'd0);
    check("R9 word unchanged", 48'(rx_word), 48'h6C1);
    one_word("R9 fresh", 48'hE7);

    // random mix
    for (int r = 0; r < 20; r++) begin
      cpol = 1'($urandom); cpha = 1'($urandom); wsize = 2'($urandom_range(0, 3));
      chain = 0; tx = 16'($urandom); sclk = cpol;
      repeat (4) @(negedge clk);
      w = wl(wsize);
      mo = 48'($urandom) & msk(w);
      one_word("R3 R11 random", mo);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule